// File: doc/BRIEF.md
# Multi-mode PWM channel bank

The block drives six pulse-width modulated output lines. All six share one clock divider and one phase counter, so they run at the same period and start each period together. Each channel holds its own duty setting, enable, output inversion and mode. The modes are a fixed duty, blinking between two duty values, and heartbeat, which ramps the duty linearly between two limits.

Software configures the bank through a single-cycle register write port. One write clears an unlock bit. After that the whole register set is frozen until the next reset, so the outputs cannot be changed.

A divider tick fires every `clk_div+1` clock cycles while the counter enable is set. The phase advances by one on each tick and wraps after `2^(resn+1)` ticks. A channel output is high while the phase is below the channel's active duty value. Blinking and heartbeat state change only at a period boundary.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low, the unlock bit is set and all other registers are zero.
- R2: Each write goes to one register, chosen by address:
  - 0 is the unlock bit, on bit 0.
  - 1 is the shared config: bits [15:0] `clk_div`, bits [19:16] `resn`, bit 31 the counter enable.
  - 2 is the channel enable mask, bits [5:0].
  - 3 is the channel invert mask, bits [5:0].
  - Channel n uses address 4+4n for the duty pair: first value in [15:0], second value in [31:16].
  - Address 5+4n is the mode: bit 0 blink, bit 1 heartbeat.
  - Address 6+4n holds the parameters X in [15:0] and Y in [31:16].
- R3: While the counter is enabled, the period is `(clk_div+1)*2^(resn+1)` clock cycles. While it is disabled, the phase is held at zero and every output sits at its inactive level.
- R4: In standard mode a pulse starts each period and lasts `duty_first*(clk_div+1)` cycles. A duty of zero gives a constant low output. A duty of at least `2^(resn+1)` gives a constant high output.
- R5: A disabled channel drives low before inversion.
- R6: Setting a channel's invert bit flips its output polarity, whether the channel is enabled or not.
- R7: In blinking mode, starting from the counter being enabled, the channel uses the first duty for X+1 periods, then the second duty for Y+1 periods, and repeats.
- R8: In heartbeat mode, the heartbeat bit takes priority over the blink bit, and the two duty values act as limits in either order.
  - The duty starts at the lower limit.
  - After every X+1 periods it moves by Y+1: up until it reaches or passes the upper limit, then down until it reaches or passes the lower limit, clamping at each limit.
- R9: Writing 0 to the unlock bit ignores all later writes, including attempts to set it again, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| pwm_o | output | 6 | Pulse output, one per channel |

## Verification
The assertions take for granted that the write port is free of X and is sampled only on clock edges. The heartbeat range property also takes for granted that the active duty starts inside the limits, which happens because it is reloaded to the lower limit whenever the channel stops running. The stimulus keeps inside these conditions in one way: it always clears the counter enable before reprogramming, and sets it again only after all of a channel's registers are written. Every measured pulse sequence therefore begins at phase zero with the mode state at its starting point.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int DC_W   = 16;
  parameter int DIV_W  = 16;
  parameter int RESN_W = 4;
  parameter int DATA_W = 32;

  parameter int A_UNLOCK  = 0;
  parameter int A_CFG     = 1;
  parameter int A_EN      = 2;
  parameter int A_INV     = 3;
  parameter int A_CH_BASE = 4;
  parameter int CH_STRIDE = 4;

  typedef struct packed {
    logic [DC_W-1:0] duty_a;
    logic [DC_W-1:0] duty_b;
    logic [DC_W-1:0] x_cnt;
    logic [DC_W-1:0] y_cnt;
    logic            blink;
    logic            hb;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DIV_W-1:0]     clk_div_o,
  output logic [RESN_W-1:0]    resn_o,
  output logic                 cntr_en_o,
  output logic [NUM_CH-1:0]    en_o,
  output logic [NUM_CH-1:0]    inv_o,
  output ch_cfg_t              ch_cfg_o [NUM_CH]
);
  logic unlock_q;
  logic wr_ok;
  assign wr_ok = wr_en_i && unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q  <= 1'b1;
      clk_div_o <= '0;
      resn_o    <= '0;
      cntr_en_o <= 1'b0;
      en_o      <= '0;
      inv_o     <= '0;
    end else if (wr_ok) begin
      if (wr_addr_i == ADDR_W'(A_UNLOCK) && !wr_data_i[0]) unlock_q <= 1'b0;
      if (wr_addr_i == ADDR_W'(A_CFG)) begin
        clk_div_o <= wr_data_i[DIV_W-1:0];
        resn_o    <= wr_data_i[16 +: RESN_W];
        cntr_en_o <= wr_data_i[DATA_W-1];
      end
      if (wr_addr_i == ADDR_W'(A_EN))  en_o  <= wr_data_i[NUM_CH-1:0];
      if (wr_addr_i == ADDR_W'(A_INV)) inv_o <= wr_data_i[NUM_CH-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_regs
    localparam int Base = A_CH_BASE + i * CH_STRIDE;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_cfg_o[i] <= '0;
      end else if (wr_ok) begin
        if (wr_addr_i == ADDR_W'(Base)) begin
          ch_cfg_o[i].duty_a <= wr_data_i[DC_W-1:0];
          ch_cfg_o[i].duty_b <= wr_data_i[16 +: DC_W];
        end
        if (wr_addr_i == ADDR_W'(Base + 1)) begin
          ch_cfg_o[i].blink <= wr_data_i[0];
          ch_cfg_o[i].hb    <= wr_data_i[1];
        end
        if (wr_addr_i == ADDR_W'(Base + 2)) begin
          ch_cfg_o[i].x_cnt <= wr_data_i[DC_W-1:0];
          ch_cfg_o[i].y_cnt <= wr_data_i[16 +: DC_W];
        end
      end
    end
  end

  // R9: once cleared, the unlock bit stays cleared
  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> !unlock_q);
  // R9: nothing moves while locked
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> ($stable(clk_div_o) && $stable(resn_o) && $stable(cntr_en_o)
                   && $stable(en_o) && $stable(inv_o)));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [RESN_W-1:0] resn_i,
  input  logic              cntr_en_i,
  output logic [DC_W-1:0]   phase_o,
  output logic              cycle_end_o
);
  logic [DIV_W-1:0] div_q;
  logic [DC_W-1:0]  phase_q;
  logic [RESN_W:0]  shift;
  logic [DC_W-1:0]  mask;
  logic             tick;

  assign shift = {1'b0, resn_i} + 1'b1;
  assign mask  = ~({DC_W{1'b1}} << shift);
  assign tick  = cntr_en_i && (div_q >= clk_div_i);
  assign cycle_end_o = tick && (phase_q >= mask);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (!cntr_en_i) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= (phase_q >= mask) ? '0 : phase_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: halted counter sits at zero
  a_r3_halt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cntr_en_i |=> (phase_q == '0 && div_q == '0));
  // R3: phase only moves on a divider tick
  a_r3_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cntr_en_i && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            inv_i,
  input  ch_cfg_t         cfg_i,
  input  logic [DC_W-1:0] phase_i,
  input  logic            cycle_end_i,
  output logic            pwm_o
);
  logic [DC_W-1:0] act_q, cnt_q, lo, hi, start;
  logic            sel_q, up_q, out_q;
  logic [DC_W:0]   step, sum, floor_v;

  assign lo      = (cfg_i.duty_a < cfg_i.duty_b) ? cfg_i.duty_a : cfg_i.duty_b;
  assign hi      = (cfg_i.duty_a < cfg_i.duty_b) ? cfg_i.duty_b : cfg_i.duty_a;
  assign start   = cfg_i.hb ? lo : cfg_i.duty_a;
  assign step    = {1'b0, cfg_i.y_cnt} + 1'b1;
  assign sum     = {1'b0, act_q} + step;
  assign floor_v = {1'b0, lo} + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      sel_q <= 1'b0;
      up_q  <= 1'b1;
    end else if (!run_i) begin
      act_q <= start;
      cnt_q <= '0;
      sel_q <= 1'b0;
      up_q  <= 1'b1;
    end else if (cycle_end_i) begin
      if (cfg_i.hb) begin
        if (cnt_q == cfg_i.x_cnt) begin
          cnt_q <= '0;
          if (up_q) begin
            if (sum >= {1'b0, hi}) begin
              act_q <= hi;
              up_q  <= 1'b0;
            end else begin
              act_q <= sum[DC_W-1:0];
            end
          end else if ({1'b0, act_q} <= floor_v) begin
            act_q <= lo;
            up_q  <= 1'b1;
          end else begin
            act_q <= act_q - step[DC_W-1:0];
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cfg_i.blink) begin
        if (cnt_q == (sel_q ? cfg_i.y_cnt : cfg_i.x_cnt)) begin
          cnt_q <= '0;
          sel_q <= ~sel_q;
          act_q <= sel_q ? cfg_i.duty_a : cfg_i.duty_b;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          act_q <= sel_q ? cfg_i.duty_b : cfg_i.duty_a;
        end
      end else begin
        act_q <= cfg_i.duty_a;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= (run_i && (phase_i < act_q)) ^ inv_i;
  end
  assign pwm_o = out_q;

  // R5: idle channel drives its inactive level
  a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (out_q == $past(inv_i)));
  // R4: duty only changes at a period boundary while running
  a_r4_duty_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cycle_end_i) |=> $stable(act_q));
  // R8: heartbeat duty stays between the limits
  a_r8_hb_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_i.hb && act_q >= lo && act_q <= hi)
      |=> (act_q >= $past(lo) && act_q <= $past(hi)));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [DIV_W-1:0]  clk_div;
  logic [RESN_W-1:0] resn;
  logic              cntr_en;
  logic [NUM_CH-1:0] en, inv;
  ch_cfg_t           ch_cfg [NUM_CH];
  logic [DC_W-1:0]   phase;
  logic              cycle_end;

  pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .clk_div_o(clk_div), .resn_o(resn), .cntr_en_o(cntr_en),
    .en_o(en), .inv_o(inv), .ch_cfg_o(ch_cfg)
  );

  pwm_timebase u_tb (
    .clk_i, .rst_ni, .clk_div_i(clk_div), .resn_i(resn), .cntr_en_i(cntr_en),
    .phase_o(phase), .cycle_end_o(cycle_end)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel u_ch (
      .clk_i, .rst_ni,
      .run_i(en[i] && cntr_en), .inv_i(inv[i]), .cfg_i(ch_cfg[i]),
      .phase_i(phase), .cycle_end_i(cycle_end), .pwm_o(pwm_o[i])
    );
  end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  pwm;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  pwm_bank u_dut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
                  .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm));

  localparam logic [31:0] RUN = 32'h8000_0000;

  function automatic logic [31:0] cfg_word(bit run, int resn, int div);
    return (run ? RUN : 32'h0) | (32'(resn) << 16) | 32'(div);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // width of the next pulse at level lvl
  task automatic pulse(input int ch, input bit lvl, output int w);
    int g = 0;
    w = 0;
    while (pwm[ch] == lvl && g < 5000) begin @(negedge clk); g++; end
    while (pwm[ch] != lvl && g < 5000) begin @(negedge clk); g++; end
    while (pwm[ch] == lvl && g < 5000) begin @(negedge clk); g++; w++; end
  endtask

  task automatic period(input int ch, output int p);
    int g = 0;
    p = 0;
    while (pwm[ch] == 1'b1 && g < 5000) begin @(negedge clk); g++; end
    while (pwm[ch] == 1'b0 && g < 5000) begin @(negedge clk); g++; end
    while (pwm[ch] == 1'b1 && g < 5000) begin @(negedge clk); g++; p++; end
    while (pwm[ch] == 1'b0 && g < 5000) begin @(negedge clk); g++; p++; end
  endtask

  task automatic highs(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm[ch]) h++; end
  endtask

  task automatic t_reset();
    int h;
    for (int c = 0; c < 6; c++) begin
      highs(c, 16, h);
      check(h == 0, "R1 reset low", h, 0);
    end
    wr(1, cfg_word(1, 3, 1));
    highs(0, 64, h);
    check(h == 0, "R1 enables cleared", h, 0);
  endtask

  task automatic t_standard();
    int w, p;
    wr(1, cfg_word(0, 3, 1));
    wr(4, 32'd5); wr(8, 32'd12); wr(2, 32'h03);
    wr(1, cfg_word(1, 3, 1));
    pulse(0, 1, w); check(w == 10, "R4 R2 ch0 width", w, 10);
    pulse(1, 1, w); check(w == 24, "R4 R2 ch1 width", w, 24);
    period(0, p);   check(p == 32, "R3 period", p, 32);
    wr(1, cfg_word(0, 2, 2));
    wr(1, cfg_word(1, 2, 2));
    pulse(0, 1, w); check(w == 15, "R3 resn width", w, 15);
    period(0, p);   check(p == 24, "R3 resn period", p, 24);
    wr(1, cfg_word(0, 3, 1));
    highs(0, 64, w); check(w == 0, "R3 halted inactive", w, 0);
  endtask

  task automatic t_limits();
    int h;
    wr(20, 32'd0); wr(24, 32'd20); wr(2, 32'h30);
    wr(1, cfg_word(1, 3, 1));
    highs(4, 96, h); check(h == 0,  "R4 duty zero low", h, 0);
    highs(5, 96, h); check(h == 96, "R4 duty full high", h, 96);
  endtask

  task automatic t_en_inv();
    int h, w;
    wr(1, cfg_word(0, 3, 1));
    wr(12, 32'd7); wr(16, 32'd4); wr(2, 32'h08);
    wr(1, cfg_word(1, 3, 1));
    highs(2, 96, h); check(h == 0, "R5 disabled low", h, 0);
    wr(3, 32'h0C);
    highs(2, 96, h); check(h == 96, "R6 disabled inverted high", h, 96);
    pulse(3, 0, w);  check(w == 8, "R6 inverted low width", w, 8);
    wr(3, 32'h00);
  endtask

  task automatic t_blink();
    int w;
    int exp [6] = '{4, 4, 12, 4, 4, 12};
    wr(1, cfg_word(0, 3, 1));
    wr(2, 32'h01);
    wr(4, {16'd6, 16'd2}); wr(5, 32'h1); wr(6, {16'd0, 16'd1});
    wr(1, cfg_word(1, 3, 1));
    for (int i = 0; i < 6; i++) begin
      pulse(0, 1, w);
      check(w == exp[i], $sformatf("R7 blink pulse %0d", i), w, exp[i]);
    end
  endtask

  task automatic t_hb();
    int w;
    int exp [10] = '{4, 8, 12, 16, 12, 8, 4, 8, 12, 16};
    wr(1, cfg_word(0, 3, 1));
    wr(2, 32'h02);
    wr(8, {16'd2, 16'd8}); wr(9, 32'h3); wr(10, {16'd1, 16'd0});
    wr(1, cfg_word(1, 3, 1));
    for (int i = 0; i < 10; i++) begin
      pulse(1, 1, w);
      check(w == exp[i], $sformatf("R8 heartbeat pulse %0d", i), w, exp[i]);
    end
  endtask

  task automatic t_lock();
    int w, p;
    wr(1, cfg_word(0, 3, 1));
    wr(4, 32'd5); wr(5, 32'h0); wr(2, 32'h01);
    wr(1, cfg_word(1, 3, 1));
    wr(0, 32'h0);
    wr(4, 32'd9); wr(0, 32'h1); wr(1, cfg_word(0, 3, 1)); wr(2, 32'h00);
    pulse(0, 1, w); check(w == 10, "R9 locked width", w, 10);
    period(0, p);   check(p == 32, "R9 locked period", p, 32);
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_standard();
    t_limits();
    t_en_inv();
    t_blink();
    t_hb();
    t_lock();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule